// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register reads and writes on the Ethernet MII management bus. It divides the system clock down to the management clock (MDC). It drives the shared data line through a separate output and output-enable pair, and it watches the line through an input that passes a two-flop synchronizer. A request gives the direction, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block then sends the whole frame on its own and reports the result with a one-cycle done pulse.

A read is checked at the turnaround. The attached PHY must pull the second turnaround bit low. If that bit is seen high, no PHY answered or the bus is confused. In that case the block stops listening for data and sends a run of idle clocks with the line released, so the PHYs can resynchronise. It then completes with an error flag and zero read data.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles in which the master drives the data line to 1.
- R2: After the opening run, the master drives the start pattern 0 then 1, followed by the opcode: 1,0 for a read or 0,1 for a write.
- R3: After the opcode, the master drives the PHY address and then the register address, 5 bits each, most significant bit first. The output enable is high for all of the first 46 MDC cycles.
- R4: The output value and the output enable never change while MDC is high. They change only in the cycle where MDC falls, or while MDC is low.
- R5: On a read, the master releases the line (output enable low) from the first turnaround cycle (MDC cycle 46) to the end of the frame.
- R6: On a read where the line is high at the end of the second turnaround cycle, the master sends 32 further released MDC cycles, for 80 MDC cycles in total. It then pulses done with err=1 and rdata=0.
- R7: On a successful read, 16 data bits are sampled most significant bit first at the end of each MDC high phase (cycles 48 to 63). Two more released MDC cycles follow, for 66 in total. The block then pulses done with err=0 and the assembled rdata.
- R8: On a write, the master drives the turnaround bits 1 then 0 and the 16 data bits most significant bit first. It then releases the line for one final MDC cycle, for 65 in total. It completes with err=0 and rdata=0.
- R9: A start is accepted only while busy is low. Request inputs are captured at acceptance. Busy stays high until done, and done is a single-cycle pulse that arrives with busy low. Rdata and err hold their values until the next accepted start.
- R10: While a frame runs, each MDC high phase and each low phase lasts DIV_HALF system cycles. The default of 25 gives 2.5 MHz from a 125 MHz clock. Between frames MDC stays low.
- R11: A synchronous active-high reset returns the block to idle at once, with MDC low, the output enable low, busy low and done low. This holds in the middle of a frame too.
- R12: The input is sampled through a two-stage synchronizer at the last system cycle of each MDC high phase. With DIV_HALF of 3 or more, a bit the PHY drives just after the MDC rising edge is the bit captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Request pulse, taken only while busy is low |
| req_read | input | 1 | 1 for a read, 0 for a write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround check failed on the last read |
| rdata | output | 16 | Data from the last successful read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value when driven |
| mdio_oe | output | 1 | Line drive enable |
| mdio_i | input | 1 | Line value observed |

## Verification
The bench runs at the smallest legal divider, where the synchronizer delay leaves exactly one cycle of margin. A sample point placed one cycle too early would read the previous bit and shift every read result by one place. Turnaround failure is driven two ways: the PHY drives a 1, or no PHY answers and the line floats high. A design that skipped the check, or used the wrong recovery length, returns data or a wrong MDC count. A start pulse in the middle of a frame, and request inputs changed after acceptance, catch a design that restarts or re-latches while busy. A reset in the middle of a frame catches state that survives reset.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_TA,
        PH_DATA,
        PH_TAIL,
        PH_RECOV
    } phase_e;

    localparam int PRE_SLOTS   = 32;
    localparam int RECOV_SLOTS = 32;
    localparam int RD_TAIL     = 2;
    localparam int WR_TAIL     = 1;
    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_RD     = 2'b10;
    localparam logic [1:0] OP_WR     = 2'b01;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic mdc_o,
    output logic fall_tick_o
);
    localparam int CW = $clog2(DIV_HALF + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } cg_t;

    cg_t  q, d;
    logic at_end;

    assign at_end = (q.cnt == CW'(DIV_HALF - 1));

    always_comb begin
        d = q;
        if (!run_i) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (at_end) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign mdc_o       = q.mdc;
    assign fall_tick_o = run_i && q.mdc && at_end;

    // R10: a phase keeps its level until its count is used up
    p_phase_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (run_i && !at_end) |=> $stable(q.mdc));
    // R10: the level flips when the count ends
    p_phase_flip_r10: assert property (@(posedge clk) disable iff (rst)
        (run_i && at_end) |=> (q.mdc != $past(q.mdc)));
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              read_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic              mdc_i,
    input  logic              sin_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int HW = 2 * ADDR_W + 4;
    localparam int CW = $clog2(PRE_SLOTS + RECOV_SLOTS + HW + DATA_W);

    typedef struct packed {
        phase_e            ph;
        logic [CW-1:0]     cnt;
        logic              rd;
        logic [HW-1:0]     hdr;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rdata;
        logic              busy;
        logic              done;
        logic              err;
        logic              o;
        logic              oe;
    } seq_t;

    seq_t          q, d;
    logic [CW-1:0] tail_last;

    assign tail_last = q.rd ? CW'(RD_TAIL - 1) : CW'(WR_TAIL - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.ph == PH_IDLE) begin
            if (start_i) begin
                d.ph    = PH_PRE;
                d.cnt   = '0;
                d.rd    = read_i;
                d.hdr   = {START_PAT, (read_i ? OP_RD : OP_WR), phy_i, reg_i};
                d.sh    = wdata_i;
                d.rdata = '0;
                d.err   = 1'b0;
                d.busy  = 1'b1;
                d.oe    = 1'b1;
                d.o     = 1'b1;
            end
        end else if (tick_i) begin
            d.cnt = q.cnt + CW'(1);
            case (q.ph)
                PH_PRE: begin
                    if (q.cnt == CW'(PRE_SLOTS - 1)) begin
                        d.ph  = PH_HDR;
                        d.cnt = '0;
                        d.o   = q.hdr[HW-1];
                    end
                end
                PH_HDR: begin
                    d.hdr = q.hdr << 1;
                    if (q.cnt == CW'(HW - 1)) begin
                        d.ph  = PH_TA;
                        d.cnt = '0;
                        d.oe  = ~q.rd;
                        d.o   = 1'b1;
                    end else begin
                        d.o = q.hdr[HW-2];
                    end
                end
                PH_TA: begin
                    if (q.cnt == '0) begin
                        d.o = q.rd;
                    end else if (q.rd && sin_i) begin
                        d.ph  = PH_RECOV;
                        d.cnt = '0;
                        d.o   = 1'b1;
                    end else begin
                        d.ph  = PH_DATA;
                        d.cnt = '0;
                        d.o   = q.rd ? 1'b1 : q.sh[DATA_W-1];
                    end
                end
                PH_DATA: begin
                    if (q.rd) d.sh = {q.sh[DATA_W-2:0], sin_i};
                    else      d.sh = q.sh << 1;
                    if (q.cnt == CW'(DATA_W - 1)) begin
                        d.ph  = PH_TAIL;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.o   = 1'b1;
                    end else if (!q.rd) begin
                        d.o = q.sh[DATA_W-2];
                    end
                end
                PH_TAIL: begin
                    if (q.cnt == tail_last) begin
                        d.ph    = PH_IDLE;
                        d.cnt   = '0;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.rdata = q.rd ? q.sh : '0;
                    end
                end
                PH_RECOV: begin
                    if (q.cnt == CW'(RECOV_SLOTS - 1)) begin
                        d.ph   = PH_IDLE;
                        d.cnt  = '0;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.ph <= PH_IDLE;
            q.o  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign err_o     = q.err;
    assign rdata_o   = q.rdata;
    assign mdio_o    = q.o;
    assign mdio_oe_o = q.oe;

    // R4: line value and enable stay put through an MDC high phase
    p_quiet_high_r4: assert property (@(posedge clk) disable iff (rst)
        (mdc_i && $past(mdc_i)) |-> ($stable(q.oe) && $stable(q.o)));
    // R5: a read never drives past the opcode
    p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
        (q.rd && (q.ph inside {PH_TA, PH_DATA, PH_TAIL, PH_RECOV})) |-> !q.oe);
    // R6: recovery only follows a read and keeps the line free
    p_recov_free_r6: assert property (@(posedge clk) disable iff (rst)
        (q.ph == PH_RECOV) |-> (q.rd && !q.oe));
    // R9: done is one cycle wide
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done);
    // R9: busy only ends on an MDC fall tick
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (q.busy && !tick_i) |=> q.busy);
    // R9: results hold while idle without a request
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!q.busy && !start_i) |=> ($stable(q.rdata) && $stable(q.err)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_HALF    = 25,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic tick;
    logic sin;
    logic busy_w;

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk         (clk),
        .rst         (rst),
        .run_i       (busy_w),
        .mdc_o       (mdc),
        .fall_tick_o (tick)
    );

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (mdio_i),
        .q_o (sin)
    );

    mdio_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (req_start),
        .read_i    (req_read),
        .phy_i     (req_phy),
        .reg_i     (req_reg),
        .wdata_i   (req_wdata),
        .tick_i    (tick),
        .mdc_i     (mdc),
        .sin_i     (sin),
        .busy_o    (busy_w),
        .done_o    (done),
        .err_o     (err),
        .rdata_o   (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    assign busy = busy_w;
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int DIV = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_start = 1'b0;
    logic        req_read  = 1'b0;
    logic [4:0]  req_phy   = '0;
    logic [4:0]  req_reg   = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        phy_oe = 1'b0;
    logic        phy_o  = 1'b1;
    logic        line_w;

    assign line_w = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master #(.DIV_HALF(DIV)) u0 (
        .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line_w)
    );

    int total = 0;
    int bad   = 0;
    int rise  = 0;
    int base  = 0;
    int kk;
    logic cap    [0:127];
    logic cap_oe [0:127];
    bit          phy_en   = 1'b0;
    bit          phy_ta   = 1'b0;
    logic [15:0] phy_data = '0;
    int   viol = 0, hi_bad = 0, hi_run = 0;
    logic prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b1;

    // PHY model: records each rising edge, answers reads just after it
    always @(posedge mdc) begin
        kk = rise - base;
        if (kk >= 0 && kk < 128) begin
            cap[kk]    = line_w;
            cap_oe[kk] = mdio_oe;
        end
        rise = rise + 1;
        #2;
        if (phy_en && kk == 47) begin
            phy_oe = 1'b1; phy_o = phy_ta;
        end else if (phy_en && kk >= 48 && kk <= 63) begin
            phy_oe = 1'b1; phy_o = phy_data[63-kk];
        end else begin
            phy_oe = 1'b0;
        end
    end

    // line quietness and high-phase width monitor
    always @(negedge clk) begin
        if (mdc && prev_mdc && ((mdio_oe != prev_oe) || (mdio_o != prev_o))) viol++;
        if (mdc) hi_run++;
        else if (prev_mdc) begin
            if (hi_run != DIV) hi_bad++;
            hi_run = 0;
        end
        prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit pen, input bit pta,
                             input logic [15:0] pd, input bit mid);
        int v0, h0, cyc, bl, rises;
        logic [45:0] hdr;
        logic [17:0] wt;
        bit oe_hdr, oe_wr, oe_rel;
        bit e_exp;
        logic [15:0] rkeep;
        logic ekeep;
        e_exp = rd && (!pen || pta);
        @(negedge clk);
        v0 = viol; h0 = hi_bad; base = rise;
        phy_en = pen; phy_ta = pta; phy_data = pd;
        req_start = 1'b1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0; req_read = ~rd; req_phy = '0; req_reg = '0; req_wdata = '0;
        chk("R9 busy after accept", 64'(busy), 64'd1);
        cyc = 0; bl = 0;
        while (done !== 1'b1 && cyc < 3000) begin
            if (busy !== 1'b1) bl++;
            if (mid && cyc == 100) begin
                req_start = 1'b1; req_read = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            end
            if (mid && cyc == 101) req_start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk("R9 frame completes", 64'(cyc < 3000), 64'd1);
        rises = rise - base;
        chk("R9 busy stays high", 64'(bl), 64'd0);
        chk("R9 busy low at done", 64'(busy), 64'd0);
        oe_hdr = 1'b1;
        for (int i = 0; i < 46; i++) begin
            hdr[45-i] = cap[i];
            oe_hdr = oe_hdr & cap_oe[i];
        end
        chk("R1 preamble", 64'(hdr[45:14]), 64'hFFFF_FFFF);
        chk("R2 start and opcode", 64'(hdr[13:10]), 64'({2'b01, (rd ? 2'b10 : 2'b01)}));
        chk("R3 phy and reg address", 64'(hdr[9:0]), 64'({phy, rg}));
        chk("R3 header driven", 64'(oe_hdr), 64'd1);
        chk("R4 no change while MDC high", 64'(viol - v0), 64'd0);
        chk("R10 high phase width", 64'(hi_bad - h0), 64'd0);
        if (!rd) begin
            oe_wr = 1'b1;
            for (int i = 46; i < 64; i++) begin
                wt[63-i] = cap[i];
                oe_wr = oe_wr & cap_oe[i];
            end
            chk("R8 turnaround and data", 64'(wt), 64'({2'b10, wd}));
            chk("R8 data driven", 64'(oe_wr), 64'd1);
            chk("R8 final cycle released", 64'(cap_oe[64]), 64'd0);
            chk("R8 MDC count", 64'(rises), 64'd65);
            chk("R8 rdata zero", 64'(rdata), 64'd0);
            chk("R8 no error", 64'(err), 64'd0);
        end else if (e_exp) begin
            oe_rel = 1'b0;
            for (int i = 46; i < 80; i++) oe_rel = oe_rel | cap_oe[i];
            chk("R6 error flag", 64'(err), 64'd1);
            chk("R6 recovery MDC count", 64'(rises), 64'd80);
            chk("R6 no data", 64'(rdata), 64'd0);
            chk("R6 released in recovery", 64'(oe_rel), 64'd0);
        end else begin
            oe_rel = 1'b0;
            for (int i = 46; i < 66; i++) oe_rel = oe_rel | cap_oe[i];
            chk("R5 released after opcode", 64'(oe_rel), 64'd0);
            chk("R7 R12 read data", 64'(rdata), 64'(pd));
            chk("R7 MDC count", 64'(rises), 64'd66);
            chk("R7 no error", 64'(err), 64'd0);
        end
        rkeep = rdata; ekeep = err;
        @(negedge clk);
        chk("R9 done single cycle", 64'(done), 64'd0);
        repeat (4) @(negedge clk);
        chk("R9 rdata held", 64'(rdata), 64'(rkeep));
        chk("R9 err held", 64'(err), 64'(ekeep));
        chk("R10 MDC low when idle", 64'(mdc), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset mdc", 64'(mdc), 64'd0);
        chk("R11 reset oe", 64'(mdio_oe), 64'd0);
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset done", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // sweep every PHY address with writes and reads
        for (int p = 0; p < 32; p++) begin
            run_frame(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0813) ^ 16'hA5C3,
                      1'b0, 1'b0, 16'h0, (p == 7));
            run_frame(1'b1, 5'(p), 5'(p ^ 5'h15), 16'h0, 1'b1, 1'b0,
                      16'(p * 16'h1357) ^ 16'h8001, (p == 9));
        end
        // data boundary values
        run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0, 1'b0, 16'h0, 1'b0);
        run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0);
        run_frame(1'b1, 5'h10, 5'h01, 16'h0, 1'b1, 1'b0, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h01, 5'h10, 16'h0, 1'b1, 1'b0, 16'h0000, 1'b0);
        // R6: turnaround failures, absent PHY and PHY driving high
        run_frame(1'b1, 5'h03, 5'h02, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
        run_frame(1'b1, 5'h04, 5'h05, 16'h0, 1'b1, 1'b1, 16'h1234, 1'b1);
        // recovery from error: good read clears err
        run_frame(1'b1, 5'h04, 5'h05, 16'h0, 1'b1, 1'b0, 16'hBEEF, 1'b0);
        // R11: reset in the middle of a frame
        @(negedge clk);
        req_start = 1'b1; req_read = 1'b0; req_phy = 5'h0A; req_reg = 5'h0B; req_wdata = 16'h5555;
        @(negedge clk);
        req_start = 1'b0;
        repeat (150) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 mid-frame reset busy", 64'(busy), 64'd0);
        chk("R11 mid-frame reset mdc", 64'(mdc), 64'd0);
        chk("R11 mid-frame reset oe", 64'(mdio_oe), 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run_frame(1'b0, 5'h0A, 5'h0B, 16'hC3A5, 1'b0, 1'b0, 16'h0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule